// File: doc/BRIEF.md
# Mask-Indexed GPIO Bank Controller

This block controls one bank of general-purpose I/O lines through a small register bus with an address, a write enable, write data, a read enable and read data. Each line has its own configuration: a function code, a direction, pull-up and pull-down enables, and a 3-bit event selector. Software does not reach a line's configuration through an address of its own. It first loads a line-select mask, then writes or reads one shared configuration port. A write lands on every selected line. A read returns the word of one selected line.

Output levels change only through write-one set and clear ports, and an output readback returns the current levels. The incoming pins pass through a two-stage synchronizer. The synchronized levels feed a pin readback port and a per-line event detector. Detected events collect in a status register that clears when it is read. Enable and disable ports set and clear an interrupt mask, and a single interrupt output is raised while any unmasked status bit is set.

Top module: `gmb_bank`

## Requirements
- R1: The ports sit at these byte addresses: line select 0x00, configuration 0x04, pin levels 0x08, output set 0x10, output clear 0x14, output levels 0x18, interrupt enable 0x20, interrupt disable 0x24, interrupt mask 0x28, interrupt status 0x2C. Read data appears in the cycle after the read enable and is zero in every other cycle. Reads of the set, clear, enable and disable ports return zero, and so do reads of any other address. Writes to any other address change nothing.
- R2: The line-select mask can be written and read back. Line n is bit n of this register and of every other per-line register.
- R3: A configuration write updates the word of every line selected in the mask and leaves every other line unchanged. With a zero mask, a configuration write does nothing. The word layout is: bits 2:0 function (0 = GPIO, 1 to 7 = peripheral), bit 8 direction (1 = output), bit 9 pull-up, bit 10 pull-down, bits 26:24 event select. All other bits are ignored and read as zero.
- R4: A configuration read returns the word of the lowest-numbered selected line. It returns zero when the mask is zero.
- R5: A write to the set port drives the output level of each line with a 1 bit high. A write to the clear port drives it low. Zero bits leave a line's level unchanged. The output-levels port reads back the current output levels.
- R6: pinOut carries the output levels. pinOe bit n is 1 only when line n has direction 1 and function 0.
- R7: The pin-levels port returns the pins as they were before two clock edges, as seen by the read. A pin change made before edge k is first returned by a read captured at edge k+2.
- R8: A write to the enable port sets the interrupt mask bits given as 1. A write to the disable port clears them. The mask reads back at 0x28.
- R9: Event select 0 flags a falling edge, 1 a rising edge and 2 either edge of the synchronized pin. A flagged event sets that line's status bit. Reading the status port returns the bits and clears them, unless an event arrives again in that same cycle.
- R10: Event select 3 flags while the pin is low and 4 while it is high, so a read cannot clear the bit while the level holds. Codes 5 to 7 flag nothing.
- R11: irqOut is high exactly when some status bit and its mask bit are both set.
- R12: Reset clears every configuration word, the line-select mask, the output levels, the interrupt mask, the status and the synchronizer, so pinOut, pinOe and irqOut are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 8 | Byte address of the access |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 32 | Write data |
| busRdEn | input | 1 | Read strobe |
| busRdData | output | 32 | Read data, valid the cycle after busRdEn |
| pinIn | input | 32 | Sampled levels of the I/O lines |
| pinOut | output | 32 | Output levels |
| pinOe | output | 32 | Per-line output enable |
| irqOut | output | 1 | Interrupt request |

## Verification
Register writes take effect at the edge that samples them. pinOut, pinOe and irqOut are checked at the falling edge that follows that write, and read data is compared at the falling edge after the read strobe's edge. A pin change needs two edges to reach the pin-levels port, so the bench issues three back-to-back reads after a change and expects the old level twice and then the new one. An event reaches the status register one edge after that. The bench therefore waits four cycles before it reads status or samples irqOut, and it repeats status reads to tell clear-on-read apart from a level event that keeps the bit set.

// File: rtl/gmb_pkg.sv
package gmb_pkg;
  localparam int BUS_W  = 32;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFF_SEL   = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_CFG   = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_PIN   = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_SET   = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_CLR   = 8'h14;
  localparam logic [ADDR_W-1:0] OFF_OUT   = 8'h18;
  localparam logic [ADDR_W-1:0] OFF_IEN   = 8'h20;
  localparam logic [ADDR_W-1:0] OFF_IDIS  = 8'h24;
  localparam logic [ADDR_W-1:0] OFF_IMASK = 8'h28;
  localparam logic [ADDR_W-1:0] OFF_ISTAT = 8'h2C;

  // bit positions inside the configuration word
  localparam int FUNC_LSB = 0;
  localparam int DIR_BIT  = 8;
  localparam int PU_BIT   = 9;
  localparam int PD_BIT   = 10;
  localparam int EVT_LSB  = 24;

  typedef enum logic [2:0] {
    EVT_FALL = 3'd0,
    EVT_RISE = 3'd1,
    EVT_BOTH = 3'd2,
    EVT_LOW  = 3'd3,
    EVT_HIGH = 3'd4
  } evtCode_e;

  typedef enum logic [2:0] {
    SRC_NONE,
    SRC_SEL,
    SRC_CFG,
    SRC_PIN,
    SRC_OUT,
    SRC_IMASK,
    SRC_ISTAT
  } rdSrc_e;

  typedef struct packed {
    logic   wrSel;
    logic   wrCfg;
    logic   wrSet;
    logic   wrClr;
    logic   wrIen;
    logic   wrIdis;
    logic   rdStat;
    logic   rdStb;
    rdSrc_e rdSrc;
  } strobe_t;

  typedef struct packed {
    logic [2:0] evt;
    logic       pd;
    logic       pu;
    logic       dir;
    logic [2:0] func;
  } lineCfg_t;

  function automatic lineCfg_t wordToCfg(input logic [BUS_W-1:0] w);
    lineCfg_t c;
    c.func = w[FUNC_LSB +: 3];
    c.dir  = w[DIR_BIT];
    c.pu   = w[PU_BIT];
    c.pd   = w[PD_BIT];
    c.evt  = w[EVT_LSB +: 3];
    return c;
  endfunction

  function automatic logic [BUS_W-1:0] cfgToWord(input lineCfg_t c);
    logic [BUS_W-1:0] w;
    w = '0;
    w[FUNC_LSB +: 3] = c.func;
    w[DIR_BIT]       = c.dir;
    w[PU_BIT]        = c.pu;
    w[PD_BIT]        = c.pd;
    w[EVT_LSB +: 3]  = c.evt;
    return w;
  endfunction
endpackage

// File: rtl/gmb_sync.sv
module gmb_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gmb_line_event.sv
module gmb_line_event
  import gmb_pkg::*;
(
  input  logic       cur,
  input  logic       prev,
  input  logic [2:0] evtSel,
  output logic       hit
);
  always_comb begin
    unique case (evtSel)
      EVT_FALL: hit = prev & ~cur;
      EVT_RISE: hit = ~prev & cur;
      EVT_BOTH: hit = prev ^ cur;
      EVT_LOW:  hit = ~cur;
      EVT_HIGH: hit = cur;
      default:  hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/gmb_ctrl.sv
module gmb_ctrl
  import gmb_pkg::*;
(
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output strobe_t           stb
);
  always_comb begin
    stb        = '0;
    stb.rdSrc  = SRC_NONE;
    stb.rdStb  = busRdEn;
    if (busWrEn) begin
      unique case (busAddr)
        OFF_SEL:  stb.wrSel  = 1'b1;
        OFF_CFG:  stb.wrCfg  = 1'b1;
        OFF_SET:  stb.wrSet  = 1'b1;
        OFF_CLR:  stb.wrClr  = 1'b1;
        OFF_IEN:  stb.wrIen  = 1'b1;
        OFF_IDIS: stb.wrIdis = 1'b1;
        default:  ;
      endcase
    end
    if (busRdEn) begin
      unique case (busAddr)
        OFF_SEL:   stb.rdSrc = SRC_SEL;
        OFF_CFG:   stb.rdSrc = SRC_CFG;
        OFF_PIN:   stb.rdSrc = SRC_PIN;
        OFF_OUT:   stb.rdSrc = SRC_OUT;
        OFF_IMASK: stb.rdSrc = SRC_IMASK;
        OFF_ISTAT: begin
          stb.rdSrc  = SRC_ISTAT;
          stb.rdStat = 1'b1;
        end
        default:   stb.rdSrc = SRC_NONE;
      endcase
    end
  end
endmodule

// File: rtl/gmb_datapath.sv
module gmb_datapath
  import gmb_pkg::*;
#(
  parameter int NUM_LINES   = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              stb,
  input  logic [BUS_W-1:0]     wrData,
  input  logic [NUM_LINES-1:0] pinIn,
  output logic [BUS_W-1:0]     rdData,
  output logic [NUM_LINES-1:0] pinOut,
  output logic [NUM_LINES-1:0] pinOe,
  output logic                 irqOut
);
  localparam int PAD_W = BUS_W - NUM_LINES;

  logic [NUM_LINES-1:0] selMask;
  logic [NUM_LINES-1:0] outLvl;
  logic [NUM_LINES-1:0] intMask;
  logic [NUM_LINES-1:0] intStat;
  logic [NUM_LINES-1:0] syncLvl;
  logic [NUM_LINES-1:0] prevLvl;
  logic [NUM_LINES-1:0] evtHit;
  lineCfg_t             cfgArr [NUM_LINES];
  lineCfg_t             pickedCfg;
  logic [BUS_W-1:0]     rdNext;
  logic [NUM_LINES-1:0] wrLines;

  assign wrLines = wrData[NUM_LINES-1:0];

  function automatic logic [BUS_W-1:0] widen(input logic [NUM_LINES-1:0] v);
    logic [BUS_W-1:0] r;
    r = '0;
    r[NUM_LINES-1:0] = v;
    return r;
  endfunction

  gmb_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) uSync (
    .clk  (clk),
    .rstN (rstN),
    .d    (pinIn),
    .q    (syncLvl)
  );

  always_ff @(posedge clk) begin
    if (!rstN) prevLvl <= '0;
    else       prevLvl <= syncLvl;
  end

  for (genvar i = 0; i < NUM_LINES; i++) begin : gLine
    always_ff @(posedge clk) begin
      if (!rstN)                        cfgArr[i] <= '0;
      else if (stb.wrCfg && selMask[i]) cfgArr[i] <= wordToCfg(wrData);
    end

    gmb_line_event uEvt (
      .cur    (syncLvl[i]),
      .prev   (prevLvl[i]),
      .evtSel (cfgArr[i].evt),
      .hit    (evtHit[i])
    );

    assign pinOe[i] = cfgArr[i].dir && (cfgArr[i].func == 3'd0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selMask <= '0;
      outLvl  <= '0;
      intMask <= '0;
      intStat <= '0;
    end else begin
      if (stb.wrSel)  selMask <= wrLines;
      if (stb.wrSet)  outLvl  <= outLvl | wrLines;
      if (stb.wrClr)  outLvl  <= outLvl & ~wrLines;
      if (stb.wrIen)  intMask <= intMask | wrLines;
      if (stb.wrIdis) intMask <= intMask & ~wrLines;
      intStat <= (stb.rdStat ? '0 : intStat) | evtHit;
    end
  end

  // lowest selected line wins: scan downward so the last hit is the lowest
  always_comb begin
    pickedCfg = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (selMask[i]) pickedCfg = cfgArr[i];
    end
  end

  always_comb begin
    unique case (stb.rdSrc)
      SRC_SEL:   rdNext = widen(selMask);
      SRC_CFG:   rdNext = cfgToWord(pickedCfg);
      SRC_PIN:   rdNext = widen(syncLvl);
      SRC_OUT:   rdNext = widen(outLvl);
      SRC_IMASK: rdNext = widen(intMask);
      SRC_ISTAT: rdNext = widen(intStat);
      default:   rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)          rdData <= '0;
    else if (stb.rdStb) rdData <= rdNext;
    else                rdData <= '0;
  end

  assign pinOut = outLvl;
  assign irqOut = |(intStat & intMask);

  if (PAD_W < 0) begin : gBadWidth
    initial $error("NUM_LINES exceeds bus width");
  end
endmodule

// File: rtl/gmb_bank.sv
module gmb_bank
  import gmb_pkg::*;
#(
  parameter int NUM_LINES   = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWrEn,
  input  logic [BUS_W-1:0]     busWrData,
  input  logic                 busRdEn,
  output logic [BUS_W-1:0]     busRdData,
  input  logic [NUM_LINES-1:0] pinIn,
  output logic [NUM_LINES-1:0] pinOut,
  output logic [NUM_LINES-1:0] pinOe,
  output logic                 irqOut
);
  strobe_t stb;

  gmb_ctrl uCtrl (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .stb     (stb)
  );

  gmb_datapath #(.NUM_LINES(NUM_LINES), .SYNC_STAGES(SYNC_STAGES)) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .wrData (busWrData),
    .pinIn  (pinIn),
    .rdData (busRdData),
    .pinOut (pinOut),
    .pinOe  (pinOe),
    .irqOut (irqOut)
  );
endmodule

// File: rtl/gmb_checker.sv
module gmb_checker
  import gmb_pkg::*;
#(
  parameter int NUM_LINES = 32
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [ADDR_W-1:0]    busAddr,
  input logic                 busWrEn,
  input logic [BUS_W-1:0]     busWrData,
  input logic                 busRdEn,
  input logic [BUS_W-1:0]     busRdData,
  input logic [NUM_LINES-1:0] pinOut,
  input logic [NUM_LINES-1:0] pinOe,
  input logic                 irqOut
);
  // R12: while reset is applied the outputs fall to zero on the next edge
  a_r12_reset_quiet: assert property (@(posedge clk)
    !rstN |=> (pinOut == '0 && pinOe == '0 && !irqOut));

  // R1: no read strobe, no read data
  a_r1_idle_rdata: assert property (@(posedge clk) disable iff (!rstN)
    !busRdEn |=> (busRdData == '0));

  // R5: set port raises every line written as 1
  a_r5_set_high: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == OFF_SET) |=>
      ((pinOut & $past(busWrData[NUM_LINES-1:0])) == $past(busWrData[NUM_LINES-1:0])));

  // R5: clear port lowers every line written as 1
  a_r5_clr_low: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == OFF_CLR) |=>
      ((pinOut & $past(busWrData[NUM_LINES-1:0])) == '0));

  // R5: an all-zero set or clear leaves the outputs alone
  a_r5_zero_noop: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && (busAddr == OFF_SET || busAddr == OFF_CLR) && busWrData[NUM_LINES-1:0] == '0)
      |=> $stable(pinOut));

  // R8 / R11: disabling every line silences the interrupt
  a_r11_disable_all: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == OFF_IDIS && busWrData[NUM_LINES-1:0] == '1) |=> !irqOut);
endmodule

bind gmb_bank gmb_checker #(.NUM_LINES(NUM_LINES)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .busAddr   (busAddr),
  .busWrEn   (busWrEn),
  .busWrData (busWrData),
  .busRdEn   (busRdEn),
  .busRdData (busRdData),
  .pinOut    (pinOut),
  .pinOe     (pinOe),
  .irqOut    (irqOut)
);

// File: tb/sim_gmb_bank.sv
`timescale 1ns/1ps
module sim_gmb_bank;
  localparam int N = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [7:0]    busAddr = '0;
  logic          busWrEn = 1'b0;
  logic [31:0]   busWrData = '0;
  logic          busRdEn = 1'b0;
  logic [31:0]   busRdData;
  logic [N-1:0]  pinIn = '0;
  logic [N-1:0]  pinOut;
  logic [N-1:0]  pinOe;
  logic          irqOut;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  logic [31:0] expQ[$];
  string       tagQ[$];
  logic        rdIssued = 1'b0;

  always #4 clk = ~clk;

  gmb_bank #(.NUM_LINES(N)) u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdEn(busRdEn), .busRdData(busRdData),
    .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe), .irqOut(irqOut)
  );

  always @(posedge clk) rdIssued <= busRdEn;

  // monitor: read data is due at the falling edge after the strobe's edge
  always @(negedge clk) begin
    if (rdIssued && !finished) begin
      logic [31:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      checks++;
      if (busRdData !== e) begin
        errors++;
        $display("FAIL %s: read data actual=%h expected=%h", t, busRdData, e);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; busWrData = '0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    expQ.push_back(e);
    tagQ.push_back(t);
    busAddr = a; busRdEn = 1'b1;
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic chk(input string t, input logic [31:0] act, input logic [31:0] e);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", t, act, e);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    finishRun();
  end

  initial begin
    cyc(3);
    rstN = 1'b1;
    cyc(1);
    // R12 reset state
    chk("R12 pinOut", pinOut, 32'h0);
    chk("R12 pinOe", pinOe, 32'h0);
    chk("R12 irqOut", {31'h0, irqOut}, 32'h0);
    rd(8'h00, 32'h0, "R12 mask after reset");
    rd(8'h18, 32'h0, "R12 outputs after reset");
    rd(8'h04, 32'h0, "R4 zero mask read");

    // R2 / R3 / R4 / R6 configuration through the mask
    wr(8'h00, 32'h0000_0011);
    rd(8'h00, 32'h0000_0011, "R2 mask readback");
    wr(8'h04, 32'h0000_0100);
    chk("R6 oe after gpio output", pinOe, 32'h0000_0011);
    rd(8'h04, 32'h0000_0100, "R4 lowest line word");
    wr(8'h00, 32'h0000_0010);
    wr(8'h04, 32'h0000_0302);
    rd(8'h04, 32'h0000_0302, "R3 fields line4");
    chk("R6 oe with peripheral function", pinOe, 32'h0000_0001);
    wr(8'h00, 32'h0000_0020);
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, 32'h0700_0707, "R3 reserved bits dropped");
    wr(8'h00, 32'h0000_0001);
    rd(8'h04, 32'h0000_0100, "R3 other line unchanged");
    wr(8'h00, 32'h0000_0000);
    wr(8'h04, 32'h0000_0100);
    chk("R3 zero mask write ignored", pinOe, 32'h0000_0001);
    wr(8'h00, 32'h0000_0011);
    rd(8'h04, 32'h0000_0100, "R3 zero mask left line0");

    // R5 set / clear outputs
    wr(8'h10, 32'h8000_0005);
    chk("R5 set", pinOut, 32'h8000_0005);
    rd(8'h18, 32'h8000_0005, "R5 readback after set");
    wr(8'h14, 32'h0000_0004);
    chk("R5 clear", pinOut, 32'h8000_0001);
    wr(8'h10, 32'h0000_0000);
    chk("R5 zero set", pinOut, 32'h8000_0001);
    wr(8'h14, 32'h0000_0000);
    chk("R5 zero clear", pinOut, 32'h8000_0001);

    // R1 address map holes and write-only ports
    rd(8'h0C, 32'h0, "R1 unlisted read");
    rd(8'h10, 32'h0, "R1 set port reads zero");
    wr(8'h30, 32'hFFFF_FFFF);
    rd(8'h00, 32'h0000_0011, "R1 stray write ignored");
    rd(8'h18, 32'h8000_0001, "R1 stray write outputs");

    // R7 pin latency: old, old, new
    pinIn = 32'h1234_5600;
    rd(8'h08, 32'h0, "R7 first read old");
    rd(8'h08, 32'h0, "R7 second read old");
    rd(8'h08, 32'h1234_5600, "R7 third read new");
    // R9 default falling edge on those lines
    pinIn = 32'h0;
    cyc(4);
    rd(8'h2C, 32'h1234_5600, "R9 falling events");
    rd(8'h2C, 32'h0, "R9 cleared by read");

    // R9 rising only, line 3
    wr(8'h00, 32'h0000_0008);
    wr(8'h04, 32'h0100_0000);
    pinIn[3] = 1'b1;
    cyc(4);
    rd(8'h2C, 32'h0000_0008, "R9 rising event");
    pinIn[3] = 1'b0;
    cyc(4);
    rd(8'h2C, 32'h0, "R9 rising ignores fall");

    // R9 both edges, line 7
    wr(8'h00, 32'h0000_0080);
    wr(8'h04, 32'h0200_0000);
    pinIn[7] = 1'b1;
    cyc(4);
    rd(8'h2C, 32'h0000_0080, "R9 both rise");
    pinIn[7] = 1'b0;
    cyc(4);
    rd(8'h2C, 32'h0000_0080, "R9 both fall");

    // R10 level events, line 6
    wr(8'h00, 32'h0000_0040);
    wr(8'h04, 32'h0300_0000);
    cyc(2);
    rd(8'h2C, 32'h0000_0040, "R10 low level");
    rd(8'h2C, 32'h0000_0040, "R10 low level persists");
    wr(8'h04, 32'h0500_0000);
    rd(8'h2C, 32'h0000_0040, "R10 pending before code 5");
    rd(8'h2C, 32'h0, "R10 code 5 silent");
    wr(8'h04, 32'h0400_0000);
    cyc(2);
    rd(8'h2C, 32'h0, "R10 high level with pin low");
    pinIn[6] = 1'b1;
    cyc(4);
    rd(8'h2C, 32'h0000_0040, "R10 high level");
    wr(8'h04, 32'h0600_0000);
    rd(8'h2C, 32'h0000_0040, "R10 pending before code 6");
    rd(8'h2C, 32'h0, "R10 code 6 silent");
    pinIn[6] = 1'b0;
    cyc(4);

    // R8 / R11 interrupt mask and output
    wr(8'h20, 32'h0000_0080);
    rd(8'h28, 32'h0000_0080, "R8 enable");
    chk("R11 no status no irq", {31'h0, irqOut}, 32'h0);
    pinIn[7] = 1'b1;
    cyc(4);
    chk("R11 irq raised", {31'h0, irqOut}, 32'h1);
    wr(8'h24, 32'h0000_0080);
    rd(8'h28, 32'h0, "R8 disable");
    chk("R11 masked irq low", {31'h0, irqOut}, 32'h0);
    rd(8'h2C, 32'h0000_0080, "R11 status kept while masked");
    wr(8'h20, 32'h0000_0080);
    pinIn[7] = 1'b0;
    cyc(4);
    chk("R11 irq on fall", {31'h0, irqOut}, 32'h1);
    rd(8'h2C, 32'h0000_0080, "R9 status before clear");
    chk("R11 irq drops after read", {31'h0, irqOut}, 32'h0);

    // R12 reset mid-run
    rstN = 1'b0;
    cyc(2);
    rstN = 1'b1;
    cyc(1);
    chk("R12 pinOut after reset", pinOut, 32'h0);
    chk("R12 pinOe after reset", pinOe, 32'h0);
    rd(8'h28, 32'h0, "R12 mask of interrupts cleared");
    rd(8'h00, 32'h0, "R12 line select cleared");
    wr(8'h00, 32'h0000_0020);
    rd(8'h04, 32'h0, "R12 config words cleared");

    cyc(2);
    finishRun();
  end
endmodule